// File: doc/BRIEF.md
# DDS command-word register loader

This block is the receiving side of a serial control link for a direct digital synthesizer. A host sends one 16-bit command word each time it holds chip select low. The block shifts the word in, decodes it, and updates the tuning state the synthesizer core reads: two 32-bit frequency tuning words, four 12-bit phase offsets, a frequency and phase selection, and a set of power and sync flags.

Values wider than a byte arrive in two steps. A staging word parks a byte in a shared holding register and changes nothing visible. A following commit word writes that held byte together with its own byte as one 16-bit half of the target register. A full tuning word therefore takes four words and a phase offset takes two. The selection of the active frequency and phase registers comes either from decoded register bits or from external pins, as set by a source flag. The block presents the selected tuning word and phase offset as registered outputs.

The serial interface is oversampled in the system clock domain. The chip select, serial clock and data lines each pass through a synchronizer, and a word is accepted only if exactly 16 serial clock rising edges occurred while chip select was low.

Top module: `dds_cmd_loader`

## Requirements
- R1: A word is sent MSB first, one bit per rising edge of `spi_sclk` while `spi_csn` is low, and is acted on when `spi_csn` rises. Bits 15:12 are the opcode, bits 11:8 a byte address and bits 7:0 a data byte.
- R2: After reset, every frequency and phase register, the holding byte and the register selects are zero. `sleep`, `core_reset` and `clear` are 1, and `sync_en` and `sel_from_reg` are 0.
- R3: Opcode 0x3 (frequency stage) and opcode 0x1 (phase stage) load the data byte into the holding register and change no visible output.
- R4: Opcode 0x2 writes {held byte, data byte} into one half of a frequency word. Address bit 2 picks word 0 or 1, address bit 1 picks bits 15:0 (0) or bits 31:16 (1), and address bit 0 is ignored. With address 8 or above the commit has no effect.
- R5: Opcode 0x0 with address 8 to 15 writes {held byte bits 3:0, data byte} into phase register (address-8)/2. With address below 8 it has no effect.
- R6: Opcode 0x6 loads the frequency register select from bit 11 and the phase register select from bits 10:9.
- R7: Any word with bits 15:14 = 10 loads `sync_en` from bit 13 and `sel_from_reg` from bit 12.
- R8: When `sel_from_reg` is 1 the active selects come from the register selects; when it is 0 they come from `pin_freq_sel` and `pin_phase_sel`. `tune_word` and `phase_word` present the register chosen by the active selects.
- R9: Any word with bits 15:14 = 11 loads `sleep` from bit 13, `core_reset` from bit 12 and `clear` from bit 11.
- R10: Opcodes 0x4, 0x5 and 0x7 are ignored. They leave every register and the holding byte unchanged.
- R11: A word with fewer or more than 16 serial clock rising edges before `spi_csn` rises is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, data sampled on its rising edge |
| spi_csn | input | 1 | Active-low chip select, one word per low period |
| spi_mosi | input | 1 | Serial data in, MSB first |
| pin_freq_sel | input | 1 | External frequency register select |
| pin_phase_sel | input | 2 | External phase register select |
| freq_words | output | 64 | Frequency words, word 0 in bits 31:0 |
| phase_words | output | 48 | Phase offsets, offset 0 in bits 11:0 |
| freq_sel_out | output | 1 | Active frequency register select |
| phase_sel_out | output | 2 | Active phase register select |
| tune_word | output | 32 | Selected frequency tuning word |
| phase_word | output | 12 | Selected phase offset |
| sync_en | output | 1 | Sync flag |
| sel_from_reg | output | 1 | Select source: 1 registers, 0 pins |
| sleep | output | 1 | Sleep flag |
| core_reset | output | 1 | Core reset flag |
| clear | output | 1 | Clear flag |

## Verification
The bench builds the block with `SYNC_STAGES` = 3, one stage more than the default. Each serial half period lasts four system clocks, so the oversampling margin is exercised with the deeper synchronizer. The package sizes stay at two 32-bit frequency words and four 12-bit phase offsets. With these sizes every byte address 0 to 15 is reachable, including odd commit addresses, phase opcodes aimed at frequency addresses and the reverse, and both selection sources with every pin value used.

// File: rtl/dds_ld_pkg.sv
package dds_ld_pkg;
  localparam int FRAME_W = 16;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 4;
  localparam int FREQ_W  = 32;
  localparam int PHASE_W = 12;
  localparam int N_FREQ  = 2;
  localparam int N_PHASE = 4;

  localparam int FSEL_W     = $clog2(N_FREQ);
  localparam int PSEL_W     = $clog2(N_PHASE);
  localparam int HALF_W     = 2 * DATA_W;
  localparam int HALVES     = FREQ_W / HALF_W;
  localparam int BYTES_PER_F = FREQ_W / DATA_W;
  localparam int PHASE_BASE = N_FREQ * BYTES_PER_F;
  localparam int PH_HI_W    = PHASE_W - DATA_W;

  localparam int OP_MSB     = 15;
  localparam int ADDR_MSB   = 11;
  localparam int SEL_F_BIT  = 11;
  localparam int SEL_P_LSB  = 9;
  localparam int FLAG_A_BIT = 13;
  localparam int FLAG_B_BIT = 12;
  localparam int FLAG_C_BIT = 11;

  typedef enum logic [2:0] {
    K_NONE,
    K_FR_STAGE,
    K_FR_COMMIT,
    K_PH_STAGE,
    K_PH_COMMIT,
    K_SELECT,
    K_SYNCSRC,
    K_POWER
  } kind_e;

  typedef struct packed {
    logic sync_en;
    logic sel_from_reg;
    logic sleep;
    logic core_reset;
    logic clear;
  } ctrl_t;

  function automatic kind_e decode_kind(input logic [3:0] op);
    kind_e k;
    if (op[3:2] == 2'b11) begin
      k = K_POWER;
    end else if (op[3:2] == 2'b10) begin
      k = K_SYNCSRC;
    end else begin
      case (op)
        4'h0:    k = K_PH_COMMIT;
        4'h1:    k = K_PH_STAGE;
        4'h2:    k = K_FR_COMMIT;
        4'h3:    k = K_FR_STAGE;
        4'h6:    k = K_SELECT;
        default: k = K_NONE;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/dds_spi_rx.sv
module dds_spi_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_data
);
  localparam int CNT_W = $clog2(WORD_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_W + 1);

  logic [SYNC_STAGES-1:0] sclk_sr, csn_sr, mosi_sr;
  logic                   sclk_d, csn_d;
  logic [WORD_W-1:0]      shreg;
  logic [CNT_W-1:0]       bit_cnt;
  logic                   s_sclk, s_csn, s_mosi, sclk_rise, csn_rise;

  assign s_sclk    = sclk_sr[SYNC_STAGES-1];
  assign s_csn     = csn_sr[SYNC_STAGES-1];
  assign s_mosi    = mosi_sr[SYNC_STAGES-1];
  assign sclk_rise = s_sclk & ~sclk_d;
  assign csn_rise  = s_csn & ~csn_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr <= '0;
      csn_sr  <= '1;
      mosi_sr <= '0;
      sclk_d  <= 1'b0;
      csn_d   <= 1'b1;
    end else begin
      sclk_sr <= {sclk_sr[SYNC_STAGES-2:0], sclk};
      csn_sr  <= {csn_sr[SYNC_STAGES-2:0], csn};
      mosi_sr <= {mosi_sr[SYNC_STAGES-2:0], mosi};
      sclk_d  <= s_sclk;
      csn_d   <= s_csn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bit_cnt   <= '0;
      word_vld  <= 1'b0;
      word_data <= '0;
    end else begin
      word_vld <= 1'b0;
      if (s_csn) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg <= {shreg[WORD_W-2:0], s_mosi};
        if (bit_cnt != CNT_OVER) bit_cnt <= bit_cnt + 1'b1;
      end
      if (csn_rise && bit_cnt == CNT_FULL) begin
        word_vld  <= 1'b1;
        word_data <= shreg;
      end
    end
  end
endmodule

// File: rtl/dds_reg_bank.sv
module dds_reg_bank
  import dds_ld_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               word_vld,
  input  logic [FRAME_W-1:0]                 word_data,
  output logic [N_FREQ-1:0][FREQ_W-1:0]      freq_q,
  output logic [N_PHASE-1:0][PHASE_W-1:0]    phase_q,
  output logic [DATA_W-1:0]                  hold_q,
  output logic [FSEL_W-1:0]                  fsel_q,
  output logic [PSEL_W-1:0]                  psel_q,
  output ctrl_t                              ctrl_q
);
  logic [3:0]        op;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] dbyte;
  kind_e             kind;
  int                addr_i, fr_word, fr_half, ph_idx;
  logic              fr_wr, ph_wr;

  always_comb begin
    op      = word_data[OP_MSB -: 4];
    addr    = word_data[ADDR_MSB -: ADDR_W];
    dbyte   = word_data[DATA_W-1:0];
    kind    = decode_kind(op);
    addr_i  = int'(addr);
    fr_word = addr_i / BYTES_PER_F;
    fr_half = (addr_i % BYTES_PER_F) / 2;
    ph_idx  = (addr_i - PHASE_BASE) / 2;
    fr_wr   = word_vld && (kind == K_FR_COMMIT) && (addr_i < PHASE_BASE);
    ph_wr   = word_vld && (kind == K_PH_COMMIT) && (addr_i >= PHASE_BASE)
              && (ph_idx < N_PHASE);
  end

  for (genvar f = 0; f < N_FREQ; f++) begin : g_freq
    logic [FREQ_W-1:0] word_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        word_r <= '0;
      end else if (fr_wr && fr_word == f) begin
        for (int h = 0; h < HALVES; h++) begin
          if (fr_half == h) word_r[h*HALF_W +: HALF_W] <= {hold_q, dbyte};
        end
      end
    end
    assign freq_q[f] = word_r;
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    logic [PHASE_W-1:0] ph_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        ph_r <= '0;
      end else if (ph_wr && ph_idx == p) begin
        ph_r <= {hold_q[PH_HI_W-1:0], dbyte};
      end
    end
    assign phase_q[p] = ph_r;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
      fsel_q <= '0;
      psel_q <= '0;
      ctrl_q <= '{sync_en: 1'b0, sel_from_reg: 1'b0,
                  sleep: 1'b1, core_reset: 1'b1, clear: 1'b1};
    end else if (word_vld) begin
      case (kind)
        K_FR_STAGE, K_PH_STAGE: hold_q <= dbyte;
        K_SELECT: begin
          fsel_q <= word_data[SEL_F_BIT -: FSEL_W];
          psel_q <= word_data[SEL_P_LSB +: PSEL_W];
        end
        K_SYNCSRC: begin
          ctrl_q.sync_en      <= word_data[FLAG_A_BIT];
          ctrl_q.sel_from_reg <= word_data[FLAG_B_BIT];
        end
        K_POWER: begin
          ctrl_q.sleep      <= word_data[FLAG_A_BIT];
          ctrl_q.core_reset <= word_data[FLAG_B_BIT];
          ctrl_q.clear      <= word_data[FLAG_C_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dds_sel_mux.sv
module dds_sel_mux
  import dds_ld_pkg::*;
(
  input  logic                            clk,
  input  logic                            rst,
  input  logic [N_FREQ-1:0][FREQ_W-1:0]   freq_q,
  input  logic [N_PHASE-1:0][PHASE_W-1:0] phase_q,
  input  logic [FSEL_W-1:0]               fsel_q,
  input  logic [PSEL_W-1:0]               psel_q,
  input  logic                            use_reg,
  input  logic [FSEL_W-1:0]               pin_fsel,
  input  logic [PSEL_W-1:0]               pin_psel,
  output logic [FSEL_W-1:0]               fsel_out,
  output logic [PSEL_W-1:0]               psel_out,
  output logic [FREQ_W-1:0]               tune_out,
  output logic [PHASE_W-1:0]              phase_out
);
  logic [FSEL_W-1:0] eff_f;
  logic [PSEL_W-1:0] eff_p;

  always_comb begin
    eff_f = use_reg ? fsel_q : pin_fsel;
    eff_p = use_reg ? psel_q : pin_psel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fsel_out  <= '0;
      psel_out  <= '0;
      tune_out  <= '0;
      phase_out <= '0;
    end else begin
      fsel_out  <= eff_f;
      psel_out  <= eff_p;
      tune_out  <= freq_q[eff_f];
      phase_out <= phase_q[eff_p];
    end
  end
endmodule

// File: rtl/dds_cmd_loader.sv
module dds_cmd_loader
  import dds_ld_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          spi_sclk,
  input  logic                          spi_csn,
  input  logic                          spi_mosi,
  input  logic [FSEL_W-1:0]             pin_freq_sel,
  input  logic [PSEL_W-1:0]             pin_phase_sel,
  output logic [N_FREQ*FREQ_W-1:0]      freq_words,
  output logic [N_PHASE*PHASE_W-1:0]    phase_words,
  output logic [FSEL_W-1:0]             freq_sel_out,
  output logic [PSEL_W-1:0]             phase_sel_out,
  output logic [FREQ_W-1:0]             tune_word,
  output logic [PHASE_W-1:0]            phase_word,
  output logic                          sync_en,
  output logic                          sel_from_reg,
  output logic                          sleep,
  output logic                          core_reset,
  output logic                          clear
);
  logic                            frm_vld;
  logic [FRAME_W-1:0]              frm_data;
  logic [N_FREQ-1:0][FREQ_W-1:0]   freq_q;
  logic [N_PHASE-1:0][PHASE_W-1:0] phase_q;
  logic [DATA_W-1:0]               hold_byte;
  logic [FSEL_W-1:0]               fsel_q;
  logic [PSEL_W-1:0]               psel_q;
  ctrl_t                           ctrl_q;

  dds_spi_rx #(.SYNC_STAGES(SYNC_STAGES), .WORD_W(FRAME_W)) u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .csn(spi_csn), .mosi(spi_mosi),
    .word_vld(frm_vld), .word_data(frm_data)
  );

  dds_reg_bank u_bank (
    .clk(clk), .rst(rst), .word_vld(frm_vld), .word_data(frm_data),
    .freq_q(freq_q), .phase_q(phase_q), .hold_q(hold_byte),
    .fsel_q(fsel_q), .psel_q(psel_q), .ctrl_q(ctrl_q)
  );

  dds_sel_mux u_mux (
    .clk(clk), .rst(rst), .freq_q(freq_q), .phase_q(phase_q),
    .fsel_q(fsel_q), .psel_q(psel_q), .use_reg(ctrl_q.sel_from_reg),
    .pin_fsel(pin_freq_sel), .pin_psel(pin_phase_sel),
    .fsel_out(freq_sel_out), .psel_out(phase_sel_out),
    .tune_out(tune_word), .phase_out(phase_word)
  );

  assign freq_words   = freq_q;
  assign phase_words  = phase_q;
  assign sync_en      = ctrl_q.sync_en;
  assign sel_from_reg = ctrl_q.sel_from_reg;
  assign sleep        = ctrl_q.sleep;
  assign core_reset   = ctrl_q.core_reset;
  assign clear        = ctrl_q.clear;
endmodule

// File: rtl/dds_cmd_loader_chk.sv
module dds_cmd_loader_chk
  import dds_ld_pkg::*;
(
  input logic                       clk,
  input logic                       rst,
  input logic                       frame_vld,
  input logic [FRAME_W-1:0]         frame_data,
  input logic [DATA_W-1:0]          hold_byte,
  input logic [N_FREQ*FREQ_W-1:0]   freq_words,
  input logic [N_PHASE*PHASE_W-1:0] phase_words,
  input logic [FSEL_W-1:0]          pin_freq_sel,
  input logic [PSEL_W-1:0]          pin_phase_sel,
  input logic [FSEL_W-1:0]          freq_sel_out,
  input logic [PSEL_W-1:0]          phase_sel_out,
  input logic                       sync_en,
  input logic                       sel_from_reg,
  input logic                       sleep,
  input logic                       core_reset,
  input logic                       clear
);
  logic [3:0] op;
  assign op = frame_data[15:12];

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (sleep && core_reset && clear && !sync_en && !sel_from_reg));

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld);

  a_r3_stage_invisible: assert property (@(posedge clk) disable iff (rst)
    frame_vld && (op == 4'h3 || op == 4'h1)
    |=> $stable(freq_words) && $stable(phase_words));

  a_r4_commit_low_half: assert property (@(posedge clk) disable iff (rst)
    frame_vld && op == 4'h2 && frame_data[11:8] == 4'h0
    |=> freq_words[15:0] == {$past(hold_byte), $past(frame_data[7:0])});

  a_r8_pin_source: assert property (@(posedge clk) disable iff (rst)
    !rst && !sel_from_reg
    |=> freq_sel_out == $past(pin_freq_sel) && phase_sel_out == $past(pin_phase_sel));

  a_r9_power_bits: assert property (@(posedge clk) disable iff (rst)
    frame_vld && frame_data[15:14] == 2'b11
    |=> sleep == $past(frame_data[13]) && core_reset == $past(frame_data[12])
        && clear == $past(frame_data[11]));

  a_r10_unknown_ignored: assert property (@(posedge clk) disable iff (rst)
    frame_vld && (op == 4'h4 || op == 4'h5 || op == 4'h7)
    |=> $stable(freq_words) && $stable(phase_words) && $stable(hold_byte)
        && $stable({sync_en, sel_from_reg, sleep, core_reset, clear}));
endmodule

bind dds_cmd_loader dds_cmd_loader_chk u_chk (
  .clk(clk), .rst(rst), .frame_vld(frm_vld), .frame_data(frm_data),
  .hold_byte(hold_byte), .freq_words(freq_words), .phase_words(phase_words),
  .pin_freq_sel(pin_freq_sel), .pin_phase_sel(pin_phase_sel),
  .freq_sel_out(freq_sel_out), .phase_sel_out(phase_sel_out),
  .sync_en(sync_en), .sel_from_reg(sel_from_reg), .sleep(sleep),
  .core_reset(core_reset), .clear(clear)
);

// File: tb/test_dds_cmd_loader.sv
module test_dds_cmd_loader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        spi_sclk = 1'b0;
  logic        spi_csn = 1'b1;
  logic        spi_mosi = 1'b0;
  logic        pin_freq_sel = 1'b0;
  logic [1:0]  pin_phase_sel = 2'b00;
  logic [63:0] freq_words;
  logic [47:0] phase_words;
  logic        freq_sel_out;
  logic [1:0]  phase_sel_out;
  logic [31:0] tune_word;
  logic [11:0] phase_word;
  logic        sync_en, sel_from_reg, sleep, core_reset, clear;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dds_cmd_loader #(.SYNC_STAGES(3)) i_dds_cmd_loader (
    .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
    .spi_mosi(spi_mosi), .pin_freq_sel(pin_freq_sel),
    .pin_phase_sel(pin_phase_sel), .freq_words(freq_words),
    .phase_words(phase_words), .freq_sel_out(freq_sel_out),
    .phase_sel_out(phase_sel_out), .tune_word(tune_word),
    .phase_word(phase_word), .sync_en(sync_en), .sel_from_reg(sel_from_reg),
    .sleep(sleep), .core_reset(core_reset), .clear(clear)
  );

  // entry: {send, req[3:0], obs[3:0], pad[6:0], frame[15:0], expect[31:0]}
  localparam int NV = 37;
  localparam logic [63:0] VEC [NV] = '{
    {1'b1, 4'd3,  4'd0, 7'd0, 16'h3312, 32'h00000000},
    {1'b1, 4'd1,  4'd0, 7'd0, 16'h2234, 32'h12340000},
    {1'b1, 4'd3,  4'd0, 7'd0, 16'h3156, 32'h12340000},
    {1'b1, 4'd4,  4'd0, 7'd0, 16'h2078, 32'h12345678},
    {1'b1, 4'd3,  4'd1, 7'd0, 16'h379A, 32'h00000000},
    {1'b1, 4'd4,  4'd1, 7'd0, 16'h26BC, 32'h9ABC0000},
    {1'b1, 4'd3,  4'd1, 7'd0, 16'h35DE, 32'h9ABC0000},
    {1'b1, 4'd4,  4'd1, 7'd0, 16'h24F0, 32'h9ABCDEF0},
    {1'b1, 4'd3,  4'd2, 7'd0, 16'h19A7, 32'h00000000},
    {1'b1, 4'd5,  4'd2, 7'd0, 16'h0865, 32'h00000765},
    {1'b1, 4'd3,  4'd3, 7'd0, 16'h1B01, 32'h00000000},
    {1'b1, 4'd5,  4'd3, 7'd0, 16'h0A23, 32'h00000123},
    {1'b1, 4'd3,  4'd4, 7'd0, 16'h1D0F, 32'h00000000},
    {1'b1, 4'd5,  4'd4, 7'd0, 16'h0CFF, 32'h00000FFF},
    {1'b1, 4'd3,  4'd5, 7'd0, 16'h1F04, 32'h00000000},
    {1'b1, 4'd5,  4'd5, 7'd0, 16'h0E56, 32'h00000456},
    {1'b1, 4'd4,  4'd1, 7'd0, 16'h2911, 32'h9ABCDEF0},
    {1'b1, 4'd5,  4'd0, 7'd0, 16'h0322, 32'h12345678},
    {1'b1, 4'd3,  4'd0, 7'd0, 16'h30AB, 32'h12345678},
    {1'b1, 4'd10, 4'd0, 7'd0, 16'h5077, 32'h12345678},
    {1'b1, 4'd10, 4'd0, 7'd0, 16'h40EE, 32'h12345678},
    {1'b1, 4'd10, 4'd0, 7'd0, 16'h7011, 32'h12345678},
    {1'b1, 4'd10, 4'd0, 7'd0, 16'h20CD, 32'h1234ABCD},
    {1'b1, 4'd3,  4'd0, 7'd0, 16'h3011, 32'h1234ABCD},
    {1'b1, 4'd4,  4'd0, 7'd0, 16'h2322, 32'h1122ABCD},
    {1'b1, 4'd9,  4'd6, 7'd0, 16'hC000, 32'h00000000},
    {1'b1, 4'd9,  4'd6, 7'd0, 16'hE800, 32'h00000005},
    {1'b1, 4'd7,  4'd6, 7'd0, 16'hB000, 32'h0000001D},
    {1'b1, 4'd7,  4'd6, 7'd0, 16'h8000, 32'h00000005},
    {1'b1, 4'd8,  4'd7, 7'd0, 16'h6E00, 32'h00000000},
    {1'b1, 4'd7,  4'd6, 7'd0, 16'h9000, 32'h0000000D},
    {1'b0, 4'd6,  4'd7, 7'd0, 16'h0000, 32'h00000007},
    {1'b0, 4'd8,  4'd8, 7'd0, 16'h0000, 32'h9ABCDEF0},
    {1'b0, 4'd8,  4'd9, 7'd0, 16'h0000, 32'h00000456},
    {1'b1, 4'd6,  4'd7, 7'd0, 16'h6200, 32'h00000001},
    {1'b0, 4'd8,  4'd9, 7'd0, 16'h0000, 32'h00000123},
    {1'b0, 4'd8,  4'd8, 7'd0, 16'h0000, 32'h1122ABCD}
  };

  function automatic string req_tag(input logic [3:0] n);
    case (n)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      4'd9:    return "R9";
      4'd10:   return "R10";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] observe(input logic [3:0] obs);
    case (obs)
      4'd0:    return freq_words[31:0];
      4'd1:    return freq_words[63:32];
      4'd2:    return {20'd0, phase_words[11:0]};
      4'd3:    return {20'd0, phase_words[23:12]};
      4'd4:    return {20'd0, phase_words[35:24]};
      4'd5:    return {20'd0, phase_words[47:36]};
      4'd6:    return {27'd0, sync_en, sel_from_reg, sleep, core_reset, clear};
      4'd7:    return {29'd0, freq_sel_out, phase_sel_out};
      4'd8:    return tune_word;
      default: return {20'd0, phase_word};
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    @(negedge clk);
    spi_csn = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      spi_mosi = (i < 16) ? w[15 - i] : 1'b0;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b1;
      repeat (4) @(negedge clk);
      spi_sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    spi_csn = 1'b1;
    repeat (14) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R2 reset state
    check("R2", "freq word 0 after reset", observe(4'd0), 32'h0);
    check("R2", "freq word 1 after reset", observe(4'd1), 32'h0);
    check("R2", "phase 3 after reset", observe(4'd5), 32'h0);
    check("R2", "flags after reset", observe(4'd6), 32'h7);
    check("R2", "active selects after reset", observe(4'd7), 32'h0);
    check("R2", "tune word after reset", observe(4'd8), 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][63]) send_bits(VEC[v][47:32], 16);
      else repeat (3) @(negedge clk);
      check(req_tag(VEC[v][62:59]), $sformatf("vector %0d", v),
            observe(VEC[v][58:55]), VEC[v][31:0]);
    end

    // R8 pins drive the selection when the source flag is clear
    send_bits(16'h8000, 16);
    pin_freq_sel  = 1'b1;
    pin_phase_sel = 2'b10;
    repeat (3) @(negedge clk);
    check("R8", "pin selects", observe(4'd7), 32'h6);
    check("R8", "pin tune word", observe(4'd8), 32'h9ABCDEF0);
    check("R8", "pin phase word", observe(4'd9), 32'hFFF);

    // R11 short and long words are dropped
    send_bits(16'hC000, 15);
    check("R11", "15-bit word dropped", observe(4'd6), 32'h5);
    send_bits(16'hC000, 17);
    check("R11", "17-bit word dropped", observe(4'd6), 32'h5);
    send_bits(16'hC000, 16);
    check("R11", "16-bit word accepted", observe(4'd6), 32'h0);

    // R2 reset mid-run restores the power-up state
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check("R2", "flags after second reset", observe(4'd6), 32'h7);
    check("R2", "freq word 0 after second reset", observe(4'd0), 32'h0);
    check("R2", "phase 2 after second reset", observe(4'd4), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule